// File: doc/BRIEF.md
# Unary Pulse-Stream Arithmetic Unit

This block performs arithmetic on two operands that arrive as unary pulse trains. Each operand travels on its own single-bit line. An operand of value N is N consecutive high cycles on that line, and the first of those cycles carries the lane's start strobe. Inside the block, each lane is turned into a binary count by a counter that advances on every qualified pulse. The selected operation is built from those counts: the two lines are merged into one counter for addition, an up/down counter is used for subtraction, and an accumulator that grows by the partner operand on every pulse forms the product.

An operation opens with the first start strobe seen while the unit is not busy. The opcode presented in that cycle is captured. The other lane may start in the same cycle or later. When both operands have ended, the unit raises a one-cycle done flag. The binary result is then held, together with the compare flags and a sticky overflow flag, until the next opening strobe. A zero-valued operand cannot be expressed as pulses, so it is signalled with an empty-operand input that accompanies the lane's start strobe.

Top module: `pulse_tally_alu`

## Requirements
- R1: An operand's value is the number of consecutive high cycles on its line, starting with the cycle of its start strobe. The operand ends in the first low cycle. After that, further pulses on the line, without a new start strobe, do not change that operand.
- R2: The opcode is sampled only in the cycle of the start strobe that opens an operation: 2'b00 add, 2'b01 subtract, 2'b10 multiply, 2'b11 compare. Later values of op_sel within the operation have no effect.
- R3: In add mode the result is A+B modulo 2^RES_W. A cycle in which both lines pulse advances the count by two.
- R4: In subtract mode the result is A-B as a two's-complement value of RES_W bits. A pulses count up and B pulses count down.
- R5: In multiply mode the result is A*B modulo 2^RES_W, for any overlap or ordering of the two pulse trains.
- R6: In compare mode, exactly one of gt, lt, eq is set at done, according to A>B, A<B or A==B, whatever the offset between the two starts. The result carries A-B.
- R7: A start strobe with the empty input high gives that lane the value zero, and the lane ends in that same cycle.
- R8: done is high for exactly one cycle. That cycle is the second clock after the cycle in which the later of the two operands ended.
- R9: result, ovf, gt, lt and eq hold their values from done until the next start strobe, even if pulses arrive without a strobe in between.
- R10: ovf is set when the true sum (add) or product (multiply) is 2^RES_W or more. It stays set until the next opening strobe clears it, and it is never set in subtract or compare mode.
- R11: After reset, result is zero and done, ovf, gt, lt and eq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 2 | Opcode, sampled at the opening start strobe |
| a_start | input | 1 | Start strobe of operand A |
| a_pulse | input | 1 | Unary pulse line of operand A |
| a_empty | input | 1 | With a_start: operand A is zero |
| b_start | input | 1 | Start strobe of operand B |
| b_pulse | input | 1 | Unary pulse line of operand B |
| b_empty | input | 1 | With b_start: operand B is zero |
| result | output | RES_W | Binary result |
| done | output | 1 | One-cycle completion flag |
| ovf | output | 1 | Sticky overflow of add or multiply |
| gt | output | 1 | Compare: A greater than B |
| lt | output | 1 | Compare: A less than B |
| eq | output | 1 | Compare: A equal to B |

## Verification
Each operation is tried with several pulse-train patterns, each chosen to tell apart a different kind of fault:
- Trains that start together and fully overlap show whether coincident pulses are counted twice.
- Staggered trains, including B starting only after A has finished, show that the multiply and compare paths depend on the counts and not on alignment.
- Empty operands probe the zero path.
- Large operands push add and multiply past 2^RES_W, which separates result wrap-around from the sticky flag, and the subtract that follows shows the flag clearing.
- Stray pulses after an operand has ended, or after done, and an opcode that changes after the opening strobe reveal state that should be ignored.

// File: rtl/upt_pkg.sv
package upt_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_MUL = 2'b10,
      OP_CMP = 2'b11
   } upt_op_e;

   localparam int LANES = 2;
endpackage

// File: rtl/upt_stream_tally.sv
// One unary lane: qualifies pulses, counts them, and flags the operand end.
module upt_stream_tally #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             strobe,
   input  logic             line,
   input  logic             empty,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] base,
   output logic             qual,
   output logic             fin
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("upt_stream_tally: CNT_W must be at least 2");
      end
   endgenerate

   logic busy;

   // a pulse counts in the strobe cycle (unless empty) or while collecting
   assign qual = line & (strobe ? ~empty : busy);
   // count before this cycle's pulse, within the current operation
   assign base = (strobe | clr) ? '0 : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         fin  <= 1'b0;
      end else if (strobe) begin
         if (empty) begin
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b1;
         end else begin
            cnt  <= {{(CNT_W-1){1'b0}}, line};
            busy <= line;
            fin  <= ~line;
         end
      end else if (clr) begin
         cnt  <= '0;
         busy <= 1'b0;
         fin  <= 1'b0;
      end else if (busy) begin
         if (line) begin
            cnt <= cnt + 1'b1;
         end else begin
            busy <= 1'b0;
            fin  <= 1'b1;
         end
      end
   end

   AST_ENDED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      fin && !strobe && !clr |=> fin && $stable(cnt)); // R1

   AST_EMPTY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && empty |=> fin && (cnt == '0)); // R7
endmodule

// File: rtl/upt_accum.sv
// Result accumulator: merged count, up/down count, or incremental product.
module upt_accum
   import upt_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  upt_op_e          op,
   input  logic             pa,
   input  logic             pb,
   input  logic [RES_W-1:0] a_base,
   input  logic [RES_W-1:0] b_base,
   output logic [RES_W-1:0] acc,
   output logic             ovf
);
   localparam int EXT_W = RES_W + 2;

   generate
      if (RES_W < 2) begin : g_bad_width
         $error("upt_accum: RES_W must be at least 2");
      end
   endgenerate

   logic [EXT_W-1:0] start_v;
   logic [EXT_W-1:0] inc_a;
   logic [EXT_W-1:0] inc_b;
   logic [EXT_W-1:0] sum_v;
   logic             hit;
   logic             ovf_base;

   assign start_v  = clr ? '0 : {2'b00, acc};
   assign ovf_base = clr ? 1'b0 : ovf;

   always_comb begin
      inc_a = '0;
      inc_b = '0;
      unique case (op)
         OP_ADD: begin
            inc_a = {{(EXT_W-1){1'b0}}, pa};
            inc_b = {{(EXT_W-1){1'b0}}, pb};
            sum_v = start_v + inc_a + inc_b;
         end
         OP_MUL: begin
            // (a+da)(b+db) = ab + da*b + db*a + da*db
            inc_a = pa ? {2'b00, b_base} : '0;
            inc_b = pb ? {2'b00, a_base} : '0;
            sum_v = start_v + inc_a + inc_b + {{(EXT_W-1){1'b0}}, pa & pb};
         end
         default: begin
            inc_a = {{(EXT_W-1){1'b0}}, pa};
            inc_b = {{(EXT_W-1){1'b0}}, pb};
            sum_v = start_v + inc_a - inc_b;
         end
      endcase
      hit = ((op == OP_ADD) || (op == OP_MUL)) && (sum_v[EXT_W-1:RES_W] != 2'b00);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         ovf <= 1'b0;
      end else begin
         acc <= sum_v[RES_W-1:0];
         ovf <= ovf_base | hit;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !clr |=> ovf); // R10

   AST_NO_OVF_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      clr && ((op == OP_SUB) || (op == OP_CMP)) |=> !ovf); // R10

   AST_IDLE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !pa && !pb |=> $stable(acc)); // R9
endmodule

// File: rtl/pulse_tally_alu.sv
module pulse_tally_alu
   import upt_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       op_sel,
   input  logic             a_start,
   input  logic             a_pulse,
   input  logic             a_empty,
   input  logic             b_start,
   input  logic             b_pulse,
   input  logic             b_empty,
   output logic [RES_W-1:0] result,
   output logic             done,
   output logic             ovf,
   output logic             gt,
   output logic             lt,
   output logic             eq
);
   generate
      if (RES_W < 2) begin : g_bad_width
         $error("pulse_tally_alu: RES_W must be at least 2");
      end
   endgenerate

   logic [LANES-1:0] ln_strobe;
   logic [LANES-1:0] ln_line;
   logic [LANES-1:0] ln_empty;
   logic [LANES-1:0] ln_qual;
   logic [LANES-1:0] ln_fin;
   logic [RES_W-1:0] ln_cnt  [LANES];
   logic [RES_W-1:0] ln_base [LANES];

   logic    running;
   logic    open_op;
   upt_op_e op_q;
   upt_op_e op_eff;

   assign ln_strobe = {b_start, a_start};
   assign ln_line   = {b_pulse, a_pulse};
   assign ln_empty  = {b_empty, a_empty};

   assign open_op = ~running & (a_start | b_start);
   assign op_eff  = open_op ? upt_op_e'(op_sel) : op_q;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         upt_stream_tally #(.CNT_W(RES_W)) u_tally (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (open_op),
            .strobe (ln_strobe[g]),
            .line   (ln_line[g]),
            .empty  (ln_empty[g]),
            .cnt    (ln_cnt[g]),
            .base   (ln_base[g]),
            .qual   (ln_qual[g]),
            .fin    (ln_fin[g])
         );
      end
   endgenerate

   upt_accum #(.RES_W(RES_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (open_op),
      .op     (op_eff),
      .pa     (ln_qual[0]),
      .pb     (ln_qual[1]),
      .a_base (ln_base[0]),
      .b_base (ln_base[1]),
      .acc    (result),
      .ovf    (ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         op_q    <= OP_ADD;
         done    <= 1'b0;
         gt      <= 1'b0;
         lt      <= 1'b0;
         eq      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (open_op) begin
            running <= 1'b1;
            op_q    <= upt_op_e'(op_sel);
            gt      <= 1'b0;
            lt      <= 1'b0;
            eq      <= 1'b0;
         end else if (running && (&ln_fin)) begin
            running <= 1'b0;
            done    <= 1'b1;
            if (op_q == OP_CMP) begin
               gt <= ln_cnt[0] >  ln_cnt[1];
               lt <= ln_cnt[0] <  ln_cnt[1];
               eq <= ln_cnt[0] == ln_cnt[1];
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(ln_fin[0] && ln_fin[1])); // R8

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gt, lt, eq})); // R6

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !a_start && !b_start |=> $stable(result) && $stable({gt, lt, eq, ovf})); // R9
endmodule

// File: tb/pulse_tally_alu_test.sv
module pulse_tally_alu_test;
   localparam int W = 8;
   localparam int MOD = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   op_sel = 2'b00;
   logic         a_start = 0, a_pulse = 0, a_empty = 0;
   logic         b_start = 0, b_pulse = 0, b_empty = 0;
   logic [W-1:0] result;
   logic         done, ovf, gt, lt, eq;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      int    res;
      bit    ov;
      bit    g;
      bit    l;
      bit    e;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   always #5 clk = ~clk;

   pulse_tally_alu #(.RES_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
      .a_start(a_start), .a_pulse(a_pulse), .a_empty(a_empty),
      .b_start(b_start), .b_pulse(b_pulse), .b_empty(b_empty),
      .result(result), .done(done), .ovf(ovf), .gt(gt), .lt(lt), .eq(eq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // monitor: compare each completed operation against the scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R8 unexpected done", 1, 0);
         end else begin
            exp_t x;
            x = sb_q.pop_front();
            check(int'(result) == x.res, {x.tag, " result"}, int'(result), x.res);
            check(ovf == x.ov, {x.tag, " R10 ovf"}, int'(ovf), int'(x.ov));
            check({gt, lt, eq} == {x.g, x.l, x.e}, {x.tag, " R6 flags gt/lt/eq"},
                  int'({gt, lt, eq}), int'({x.g, x.l, x.e}));
         end
      end
   end

   task automatic run_op(input logic [1:0] op, input int a, input int b,
                         input int ao, input int bo, input bit noise, input string tag);
      exp_t x;
      int ea, eb, e, first;
      ea = ao + a;
      eb = bo + b;
      e = (ea > eb) ? ea : eb;
      first = (ao < bo) ? ao : bo;
      x.tag = tag; x.ov = 0; x.g = 0; x.l = 0; x.e = 0;
      case (op)
         2'b00: begin x.res = (a + b) % MOD; x.ov = (a + b) >= MOD; end
         2'b01: x.res = ((a - b) % MOD + MOD) % MOD;
         2'b10: begin x.res = (a * b) % MOD; x.ov = (a * b) >= MOD; end
         default: begin
            x.res = ((a - b) % MOD + MOD) % MOD;
            x.g = a > b; x.l = a < b; x.e = a == b;
         end
      endcase
      sb_q.push_back(x);
      for (int c = 0; c <= e; c++) begin
         @(negedge clk);
         op_sel  = (c == first) ? op : ~op; // R2: later opcode changes ignored
         a_start = (c == ao);
         a_empty = (c == ao) && (a == 0);
         a_pulse = ((a > 0) && (c >= ao) && (c < ea)) || (noise && (c == ea + 1) && (c < e));
         b_start = (c == bo);
         b_empty = (c == bo) && (b == 0);
         b_pulse = (b > 0) && (c >= bo) && (c < eb);
      end
      @(negedge clk);
      {a_start, a_pulse, a_empty, b_start, b_pulse, b_empty} = '0;
      check(done == 1'b0, {tag, " R8 done early"}, int'(done), 0);
      @(negedge clk);
      check(done == 1'b1, {tag, " R8 done timing"}, int'(done), 1);
      a_pulse = 1'b1; b_pulse = 1'b1; // stray pulses with no strobe
      @(negedge clk);
      check(done == 1'b0, {tag, " R8 done width"}, int'(done), 0);
      a_pulse = 1'b0; b_pulse = 1'b0;
      @(negedge clk);
      check(int'(result) == x.res, {tag, " R9 result hold"}, int'(result), x.res);
      check(ovf == x.ov, {tag, " R9 ovf hold"}, int'(ovf), int'(x.ov));
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(result == '0, "R11 reset result", int'(result), 0);
      check({done, ovf, gt, lt, eq} == 5'b0, "R11 reset flags", int'({done, ovf, gt, lt, eq}), 0);

      run_op(2'b00, 5, 5, 0, 0, 0, "R3 add coincident");
      run_op(2'b00, 3, 7, 2, 0, 0, "R3 add staggered");
      run_op(2'b00, 200, 100, 0, 0, 0, "R10 add overflow");
      run_op(2'b01, 9, 4, 0, 0, 0, "R4 sub positive, R10 ovf cleared");
      run_op(2'b01, 3, 8, 0, 1, 0, "R4 sub negative");
      run_op(2'b00, 0, 4, 0, 0, 0, "R7 add empty A");
      run_op(2'b10, 6, 3, 0, 8, 0, "R5 mul B after A");
      run_op(2'b10, 7, 5, 0, 0, 0, "R5 mul overlapped");
      run_op(2'b10, 20, 20, 0, 3, 0, "R10 mul overflow");
      run_op(2'b10, 0, 9, 2, 0, 0, "R7 mul empty");
      run_op(2'b11, 6, 6, 0, 0, 0, "R6 cmp equal");
      run_op(2'b11, 4, 9, 0, 0, 0, "R6 cmp less");
      run_op(2'b11, 9, 4, 5, 0, 0, "R6 cmp greater offset");
      run_op(2'b11, 5, 5, 0, 3, 0, "R6 cmp equal offset");
      run_op(2'b11, 0, 0, 0, 0, 0, "R7 cmp both empty");
      run_op(2'b00, 3, 10, 0, 0, 1, "R1 add stray pulse after end");

      check(sb_q.size() == 0, "R8 all operations completed", sb_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule